// File: doc/BRIEF.md
# Amplifier Protection and Mute Sequencer

This block is the control state machine for a two-channel switching power stage. It decides when the power transistors may switch, when they must stop, and how a latched fault is released. It takes an active-low power-down pin, a mute pin, an unsigned die-temperature code and one over-current comparator flag per power transistor. It drives three error flags, a power-stage enable and a soft-start request. The soft-start request runs a controlled pulsing sequence that brings the output filter from zero up to mid-scale before full switching starts.

Every asynchronous input passes through a two-flop synchronizer. A power-down pulse only counts if it stays low for a parameterized number of clocks, so glitches shorter than that are ignored. Temperature is compared against three parameterized codes. A warning level and a shutdown level share one lower release level, which gives hysteresis. An over-current event forces the stage off and stays latched. It can only be cleared by a valid power-down pulse or by asserting and then negating mute.

Top module: `amp_prot_seq`

## Requirements
- R1: While the synchronized power-down pin has been low for at least `MIN_LOW` consecutive clocks, the block is held in reset: `stage_en`, `ramp_req` and `err_oc` are 0. A low pulse shorter than that has no effect on the outputs.
- R2: A temperature code strictly above `WARN_T` sets `err_warn`, and the stage keeps switching (`stage_en` stays 1).
- R3: A temperature code strictly above `SHUT_T` sets `err_shut` and drives `stage_en` to 0.
- R4: `err_warn` and `err_shut` each stay set until the temperature code falls strictly below `REL_T`. When it does, both clear, and the stage restarts through soft-start if mute is negated.
- R5: Any bit of `oc_flags` going high sets `err_oc` and drives `stage_en` to 0. The flag stays set after the comparator bit returns low.
- R6: A valid power-down pulse (R1) clears `err_oc`.
- R7: `err_oc` clears when mute (active high) is asserted and then negated while the fault is latched. Holding mute negated, or only asserting it, leaves `err_oc` set.
- R8: On leaving reset or mute with no fault pending, `ramp_req` is high for exactly `RAMP_CYC` consecutive clocks with `stage_en` at 0. `stage_en` goes to 1 on the clock after that.
- R9: Mute, a thermal shutdown or an over-current during soft-start ends `ramp_req` without `stage_en` ever rising.
- R10: Mute asserted while running drives `stage_en` low on the third clock edge after the pin changes. That is 60 ns at 50 MHz, well inside 5 µs.
- R11: While `err_shut` is set, negating mute starts neither soft-start nor switching.
- R12: `stage_en` is never 1 while `err_oc` is 1, and never 1 on the clock after `err_shut` is seen at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| pdn_n_pin | input | 1 | Power-down pin, active low, asynchronous |
| mute_pin | input | 1 | Mute pin, active high, asynchronous |
| temp_code | input | TEMP_W | Unsigned die-temperature code |
| oc_flags | input | N_SW | Over-current comparator flag per transistor |
| err_oc | output | 1 | Latched over-current error |
| err_warn | output | 1 | Thermal warning |
| err_shut | output | 1 | Thermal shutdown |
| stage_en | output | 1 | Power stage may switch normally |
| ramp_req | output | 1 | Soft-start pulsing request |

## Verification
On every cycle the assertions check the following:
- the reset filter only fires after an unbroken low run;
- the thermal flags follow the set and hold rules for the current code;
- a running stage leaves RUN one clock after a synchronized mute;
- soft-start only completes on its last count;
- the over-current flag only falls after a power-down or a mute release;
- the enable never overlaps an active error.

Only the bench scenarios can show the full behaviour over time. These cover the exact soft-start length, the rejection of a short power-down glitch, the temperature sweep across all three levels in both directions, and each over-current clear path, including the paths that must not clear it. They also cover the pin-to-enable latency of mute and the precedence of shutdown over mute release.

// File: rtl/amp_prot_pkg.sv
`timescale 1ns/1ps
package amp_prot_pkg;
    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_MUTED = 3'd1,
        ST_RAMP  = 3'd2,
        ST_RUN   = 3'd3,
        ST_TSHUT = 3'd4,
        ST_OCLAT = 3'd5
    } amp_state_e;
endpackage

// File: rtl/amp_sync.sv
`timescale 1ns/1ps
module amp_sync #(
    parameter int          W       = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= {W{RST_VAL}};
            s2_q <= {W{RST_VAL}};
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/amp_pdn_filter.sv
`timescale 1ns/1ps
module amp_pdn_filter #(
    parameter int MIN_LOW = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    output logic hold
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hold;
    } filt_t;

    filt_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (pin_s) begin
            r_d.cnt  = '0;
            r_d.hold = 1'b0;
        end else if (r_q.cnt == LAST) begin
            r_d.hold = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: '0, hold: 1'b1};
        else        r_q <= r_d;
    end

    assign hold = r_q.hold;

    // R1: a reset is only recognised after the pin was low for several cycles
    a_r1_needs_low_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.hold) |-> ($past(!pin_s, 1) && $past(!pin_s, 2)));
endmodule

// File: rtl/amp_thermal.sv
`timescale 1ns/1ps
module amp_thermal #(
    parameter int TEMP_W = 8,
    parameter int WARN_T = 135,
    parameter int SHUT_T = 150,
    parameter int REL_T  = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_s,
    output logic              warn,
    output logic              shut
);
    localparam logic [TEMP_W-1:0] WARN_C = TEMP_W'(WARN_T);
    localparam logic [TEMP_W-1:0] SHUT_C = TEMP_W'(SHUT_T);
    localparam logic [TEMP_W-1:0] REL_C  = TEMP_W'(REL_T);

    typedef struct packed {
        logic warn;
        logic shut;
    } therm_t;

    therm_t r_d, r_q;
    logic   cool;

    always_comb begin
        cool   = (temp_s < REL_C);
        r_d.warn = r_q.warn ? !cool : (temp_s > WARN_C);
        r_d.shut = r_q.shut ? !cool : (temp_s > SHUT_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign warn = r_q.warn;
    assign shut = r_q.shut;

    // R2: code above the warning level raises the warning next cycle
    a_r2_warn_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_s > WARN_C) |=> r_q.warn);
    // R3: code above the shutdown level raises shutdown next cycle
    a_r3_shut_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_s > SHUT_C) |=> r_q.shut);
    // R4: flags hold until the code drops under the release level
    a_r4_warn_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.warn && temp_s >= REL_C) |=> r_q.warn);
    a_r4_shut_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.shut && temp_s >= REL_C) |=> r_q.shut);
endmodule

// File: rtl/amp_prot_seq.sv
`timescale 1ns/1ps
module amp_prot_seq
    import amp_prot_pkg::*;
#(
    parameter int TEMP_W   = 8,
    parameter int N_SW     = 8,
    parameter int WARN_T   = 135,
    parameter int SHUT_T   = 150,
    parameter int REL_T    = 120,
    parameter int MIN_LOW  = 25,
    parameter int RAMP_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn_n_pin,
    input  logic              mute_pin,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [N_SW-1:0]   oc_flags,
    output logic              err_oc,
    output logic              err_warn,
    output logic              err_shut,
    output logic              stage_en,
    output logic              ramp_req
);
    localparam int RCW = (RAMP_CYC > 1) ? $clog2(RAMP_CYC) : 1;
    localparam logic [RCW-1:0] RAMP_LAST = RCW'(RAMP_CYC - 1);

    logic              pdn_s, mute_s, rst_hold, warn, shut, oc_any;
    logic [TEMP_W-1:0] temp_s;
    logic [N_SW-1:0]   oc_s;

    amp_sync #(.W(1), .RST_VAL(1'b0)) u_sync_pdn (
        .clk(clk), .rst_n(rst_n), .din(pdn_n_pin), .dout(pdn_s));
    amp_sync #(.W(1), .RST_VAL(1'b1)) u_sync_mute (
        .clk(clk), .rst_n(rst_n), .din(mute_pin), .dout(mute_s));
    amp_sync #(.W(TEMP_W), .RST_VAL(1'b0)) u_sync_temp (
        .clk(clk), .rst_n(rst_n), .din(temp_code), .dout(temp_s));
    amp_sync #(.W(N_SW), .RST_VAL(1'b0)) u_sync_oc (
        .clk(clk), .rst_n(rst_n), .din(oc_flags), .dout(oc_s));

    amp_pdn_filter #(.MIN_LOW(MIN_LOW)) u_filt (
        .clk(clk), .rst_n(rst_n), .pin_s(pdn_s), .hold(rst_hold));

    amp_thermal #(.TEMP_W(TEMP_W), .WARN_T(WARN_T), .SHUT_T(SHUT_T),
                  .REL_T(REL_T)) u_therm (
        .clk(clk), .rst_n(rst_n), .temp_s(temp_s), .warn(warn), .shut(shut));

    assign oc_any = |oc_s;

    typedef struct packed {
        amp_state_e     st;
        logic [RCW-1:0] rcnt;
        logic           oc_lat;
        logic           mute_seen;
    } seq_t;

    seq_t r_d, r_q;
    logic oc_release;

    always_comb begin
        r_d        = r_q;
        oc_release = (r_q.st == ST_OCLAT) && r_q.mute_seen && !mute_s;

        // latched over-current flag
        if (rst_hold)        r_d.oc_lat = 1'b0;
        else if (oc_any)     r_d.oc_lat = 1'b1;
        else if (oc_release) r_d.oc_lat = 1'b0;

        r_d.mute_seen = (r_q.st == ST_OCLAT) && !oc_release
                        && (r_q.mute_seen || mute_s);

        if (rst_hold) begin
            r_d.st = ST_RESET;
        end else begin
            unique case (r_q.st)
                ST_RESET: r_d.st = ST_MUTED;
                ST_MUTED: begin
                    if (shut)                      r_d.st = ST_TSHUT;
                    else if (r_q.oc_lat || oc_any) r_d.st = ST_OCLAT;
                    else if (!mute_s) begin
                        r_d.st   = ST_RAMP;
                        r_d.rcnt = '0;
                    end
                end
                ST_RAMP: begin
                    if (mute_s || shut || oc_any || r_q.oc_lat)
                        r_d.st = ST_MUTED;
                    else if (r_q.rcnt == RAMP_LAST)
                        r_d.st = ST_RUN;
                    else
                        r_d.rcnt = r_q.rcnt + 1'b1;
                end
                ST_RUN: begin
                    if (oc_any)      r_d.st = ST_OCLAT;
                    else if (shut)   r_d.st = ST_TSHUT;
                    else if (mute_s) r_d.st = ST_MUTED;
                end
                ST_TSHUT: if (!shut) r_d.st = ST_MUTED;
                ST_OCLAT: if (oc_release) r_d.st = ST_MUTED;
                default:  r_d.st = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RESET, rcnt: '0, oc_lat: 1'b0, mute_seen: 1'b0};
        else        r_q <= r_d;
    end

    assign err_oc   = r_q.oc_lat;
    assign err_warn = warn;
    assign err_shut = shut;
    assign stage_en = (r_q.st == ST_RUN);
    assign ramp_req = (r_q.st == ST_RAMP);

    // R10: synchronized mute while running leaves RUN on the next edge
    a_r10_mute_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_s && r_q.st == ST_RUN) |=> (r_q.st != ST_RUN));
    // R8: soft-start only hands over to RUN on its final count
    a_r8_ramp_full: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && $past(r_q.st) == ST_RAMP) |-> ($past(r_q.rcnt) == RAMP_LAST));
    // R6, R7: over-current flag falls only through a clear path
    a_r7_oc_clear_path: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.oc_lat) |-> ($past(rst_hold) || ($past(r_q.mute_seen) && $past(!mute_s))));
    // R12: no switching with a latched over-current
    a_r12_no_en_oc: assert property (@(posedge clk) disable iff (!rst_n)
        err_oc |-> !stage_en);
    // R12: shutdown stops switching by the next edge
    a_r12_no_en_shut: assert property (@(posedge clk) disable iff (!rst_n)
        shut |=> !stage_en);
    // R1: a recognised reset holds the stage idle
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hold |=> (!stage_en && !err_oc));
endmodule

// File: tb/sim_amp_prot_seq.sv
`timescale 1ns/1ps
module sim_amp_prot_seq;
    localparam int TW = 8, NSW = 8, MINL = 25, RC = 16;

    logic clk = 1'b0, rst_n = 1'b0, pdn_n = 1'b0, mute = 1'b1;
    logic [TW-1:0]  temp = 8'd25;
    logic [NSW-1:0] oc = '0;
    logic err_oc, err_warn, err_shut, stage_en, ramp_req;

    always #10 clk = ~clk;

    amp_prot_seq #(.TEMP_W(TW), .N_SW(NSW), .WARN_T(135), .SHUT_T(150),
                   .REL_T(120), .MIN_LOW(MINL), .RAMP_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .pdn_n_pin(pdn_n), .mute_pin(mute),
        .temp_code(temp), .oc_flags(oc), .err_oc(err_oc), .err_warn(err_warn),
        .err_shut(err_shut), .stage_en(stage_en), .ramp_req(ramp_req));

    typedef struct {
        string    tag;
        logic [4:0] exp;   // {err_oc, err_warn, err_shut, stage_en, ramp_req}
    } item_t;

    item_t sb_q[$];
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic expect_out(input string tag, input logic [4:0] e);
        item_t it;
        @(posedge clk);
        it.tag = tag; it.exp = e;
        sb_q.push_back(it);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_val(input string tag, input int got, input int e);
        n_run++;
        if (got != e) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, e);
        end
    endtask

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [4:0] got;
            it  = sb_q.pop_front();
            got = {err_oc, err_warn, err_shut, stage_en, ramp_req};
            n_run++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // waits for ramp start, counts its length, returns length
    task automatic measure_ramp(output int len);
        int guard = 0;
        len = 0;
        while (!ramp_req && guard < 200) begin @(negedge clk); guard++; end
        while (ramp_req && len < 1000) begin @(negedge clk); len++; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int len;
        cyc(3);
        rst_n = 1'b1;
        cyc(5);
        expect_out("R1 reset state", 5'b00000);
        pdn_n = 1'b1;
        cyc(8);
        expect_out("R1 released into mute", 5'b00000);

        // R8: leave mute, soft-start length
        mute = 1'b0;
        measure_ramp(len);
        chk_val("R8 ramp length after unmute", len, RC);
        expect_out("R8 running after ramp", 5'b00010);

        // R1: short power-down glitch ignored
        @(negedge clk) pdn_n = 1'b0;
        cyc(10);
        pdn_n = 1'b1;
        cyc(40);
        expect_out("R1 short glitch ignored", 5'b00010);

        // R2/R3/R4: temperature sweep
        temp = 8'd140; cyc(6);
        expect_out("R2 warn keeps running", 5'b01010);
        temp = 8'd130; cyc(6);
        expect_out("R4 warn held above release", 5'b01010);
        temp = 8'd155; cyc(6);
        expect_out("R3 shutdown stops stage", 5'b01100);
        mute = 1'b1; cyc(6); mute = 1'b0; cyc(10);
        expect_out("R11 unmute ignored in shutdown", 5'b01100);
        temp = 8'd125; cyc(6);
        expect_out("R4 both held above release", 5'b01100);
        temp = 8'd120; cyc(6);
        expect_out("R4 held at release level", 5'b01100);
        temp = 8'd110;
        measure_ramp(len);
        chk_val("R4 restart ramp after cooling", len, RC);
        expect_out("R4 flags cleared running", 5'b00010);

        // R5/R7: over-current and the mute clear path
        @(negedge clk) oc = 8'b0000_0100;
        cyc(3); oc = '0; cyc(6);
        expect_out("R5 oc latched stage off", 5'b10000);
        cyc(30);
        expect_out("R7 negated mute alone keeps oc", 5'b10000);
        mute = 1'b1; cyc(6);
        expect_out("R7 mute asserted keeps oc", 5'b10000);
        mute = 1'b0;
        measure_ramp(len);
        chk_val("R7 ramp after mute cycle", len, RC);
        expect_out("R7 oc cleared by mute cycle", 5'b00010);

        // R6: clear by power-down pulse
        @(negedge clk) oc = 8'b1000_0000;
        cyc(3); oc = '0; cyc(6);
        expect_out("R5 second oc latched", 5'b10000);
        pdn_n = 1'b0; cyc(40);
        expect_out("R6 oc cleared in reset", 5'b00000);
        pdn_n = 1'b1;
        measure_ramp(len);
        chk_val("R8 ramp after reset release", len, RC);
        expect_out("R6 running after reset", 5'b00010);

        // R10: mute latency, pin to enable low on third edge
        @(negedge clk) mute = 1'b1;
        @(posedge clk); @(posedge clk);
        #1 chk_val("R10 still running after two edges", int'(stage_en), 1);
        expect_out("R10 stage off on third edge", 5'b00000);

        // R9: abort soft-start by mute
        mute = 1'b0;
        while (!ramp_req) @(negedge clk);
        cyc(4);
        mute = 1'b1; cyc(5);
        expect_out("R9 ramp aborted by mute", 5'b00000);
        cyc(RC + 5);
        expect_out("R9 no enable after mute abort", 5'b00000);

        // R9: abort soft-start by shutdown
        mute = 1'b0;
        while (!ramp_req) @(negedge clk);
        cyc(3);
        temp = 8'd160; cyc(6);
        expect_out("R9 ramp aborted by shutdown", 5'b01100);
        temp = 8'd100;
        measure_ramp(len);
        chk_val("R9 ramp restarts after cooling", len, RC);

        // R9: abort soft-start by over-current
        mute = 1'b1; cyc(6); mute = 1'b0;
        while (!ramp_req) @(negedge clk);
        cyc(2);
        oc = 8'b0000_0001; cyc(2); oc = '0; cyc(6);
        expect_out("R9 ramp aborted by oc", 5'b10000);
        cyc(RC + 5);
        expect_out("R12 no enable with oc latched", 5'b10000);

        cyc(5);
        finish_run();
    end
endmodule